// File: doc/BRIEF.md
# RGB Pixel Point-Operation Stage

This block sits in a streaming video path and rewrites one 24-bit RGB pixel at a time. It carries 8 bits per colour. A mode input picks one of five operations: grayscale, RGB to YCbCr, inversion, brightness offset with saturation, or binary threshold. Each result depends only on the pixel in flight, so no line or frame storage is needed.

Input and output are AXI4-Stream. One output register holds the result, the start-of-frame flag and the end-of-line flag together, so the stage adds exactly one clock of latency. Backpressure from downstream stalls the register and is passed back upstream. The mode, brightness offset and threshold are sampled in the cycle a pixel is accepted.

The red component sits in bits 23:16, green in 15:8 and blue in 7:0.

Top module: `pix_point_stage`

## Requirements
- R1: Mode 0 (gray) outputs g = ((R+G+B)*171) >> 9 on all three lanes.
- R2: Mode 1 (YCbCr) outputs three values, each clamped to 0..255:
  - Y = (4R+8G+2B+256) >> 4 in bits 23:16.
  - Cb = (-2R-5G+7B+2048) >> 4 in bits 15:8.
  - Cr = (7R-6G-B+2048) >> 4 in bits 7:0.
- R3: Mode 2 (invert) replaces every component c with 255-c.
- R4: Mode 3 (brightness) adds the signed offset input (-256..255) to every component and saturates the result to 0..255.
- R5: Mode 4 (binary) outputs 0xFFFFFF when the R1 gray value is strictly greater than the threshold input, and 0x000000 otherwise, equality included.
- R6: Modes 5, 6 and 7 pass the input pixel through unchanged.
- R7: A pixel accepted on one clock edge appears on the output after that edge, one cycle of latency. Its start-of-frame and end-of-line flags travel with it.
- R8: While the output is valid and not accepted, output data and flags hold steady and valid stays high.
- R9: The input ready is low exactly when the output holds a pixel that downstream is not taking, and high otherwise.
- R10: During and right after reset the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Operation select (0 gray, 1 YCbCr, 2 invert, 3 brightness, 4 binary, other pass) |
| bright_ofs | input | 9 | Signed brightness offset |
| thresh | input | 8 | Binary threshold |
| s_tdata | input | 24 | Input pixel R,G,B |
| s_tuser | input | 1 | Input start-of-frame flag |
| s_tlast | input | 1 | Input end-of-line flag |
| s_tvalid | input | 1 | Input pixel valid |
| s_tready | output | 1 | Stage can accept a pixel |
| m_tdata | output | 24 | Result pixel |
| m_tuser | output | 1 | Result start-of-frame flag |
| m_tlast | output | 1 | Result end-of-line flag |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream accepts the result |

## Verification
Every result is due in the cycle after its input handshake, held for as long as downstream stalls. The driver pushes an expected pixel, with its flags, into a queue at the handshake. The monitor compares an output only in a cycle where valid and ready are both high, so the output order, not a fixed cycle count, decides which expected item applies. Random downstream stalls test the hold and ready rules, and the flags are checked in the same comparison as the data.

// File: rtl/pix_op_pkg.sv
`timescale 1ns/1ps
// Shared operation codes for the pixel point-operation stage.
// Assumes a 3-bit mode field; unlisted codes mean pass-through.
package pix_op_pkg;
    typedef enum logic [2:0] {
        OP_GRAY   = 3'd0,
        OP_YCC    = 3'd1,
        OP_INV    = 3'd2,
        OP_BRIGHT = 3'd3,
        OP_BIN    = 3'd4
    } op_e;
endpackage

// File: rtl/pix_lane_op.sv
`timescale 1ns/1ps
// Per-component operations: complement and saturating signed offset.
// Assumes an unsigned component and a two's-complement offset.
module pix_lane_op #(
    parameter int COMP_W = 8,
    parameter int OFS_W  = 9
) (
    input  logic [COMP_W-1:0]       comp,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [COMP_W-1:0]       inv,
    output logic [COMP_W-1:0]       bright
);
    localparam int BW = ((COMP_W > OFS_W) ? COMP_W : OFS_W) + 2;
    localparam logic signed [BW-1:0] MAXV = BW'((1 << COMP_W) - 1);

    logic signed [BW-1:0] sum;

    // Complement against full scale.
    assign inv = ~comp;

    // Add the offset, then saturate to the component range.
    always_comb begin
        sum = $signed({{(BW-COMP_W){1'b0}}, comp}) + BW'(ofs);
        if (sum < 0)
            bright = '0;
        else if (sum > MAXV)
            bright = '1;
        else
            bright = sum[COMP_W-1:0];
    end
endmodule

// File: rtl/pix_color_conv.sv
`timescale 1ns/1ps
// Division-free colour conversions: channel mean and YCbCr.
// Assumes 8-bit components; the constants are scaled for that width.
module pix_color_conv #(
    parameter int COMP_W = 8
) (
    input  logic [COMP_W-1:0] r,
    input  logic [COMP_W-1:0] g,
    input  logic [COMP_W-1:0] b,
    output logic [COMP_W-1:0] gray,
    output logic [COMP_W-1:0] y,
    output logic [COMP_W-1:0] cb,
    output logic [COMP_W-1:0] cr
);
    localparam int SUM_W  = COMP_W + 2;
    localparam int PROD_W = SUM_W + 8;
    localparam int SW     = COMP_W + 6;
    localparam logic signed [SW-1:0] Y_BIAS = SW'(1 << COMP_W);
    localparam logic signed [SW-1:0] C_BIAS = SW'(1 << (COMP_W + 3));
    localparam logic signed [SW-1:0] MAXV   = SW'((1 << COMP_W) - 1);

    logic [SUM_W-1:0]     sum3;
    logic [PROD_W-1:0]    prod;
    logic signed [SW-1:0] rs, gs, bs;
    logic signed [SW-1:0] y_acc, cb_acc, cr_acc;

    // Clamp a signed intermediate to the component range.
    function automatic logic [COMP_W-1:0] sat(input logic signed [SW-1:0] v);
        if (v < 0)
            return '0;
        else if (v > MAXV)
            return '1;
        else
            return v[COMP_W-1:0];
    endfunction

    // Mean approximation: multiply by 171, shift right by 9.
    always_comb begin
        sum3 = SUM_W'(r) + SUM_W'(g) + SUM_W'(b);
        prod = PROD_W'(sum3) * PROD_W'(171);
        gray = prod[9 +: COMP_W];
    end

    // Sixteenths-weighted YCbCr with rounding bias, then clamp.
    always_comb begin
        rs     = $signed({{(SW-COMP_W){1'b0}}, r});
        gs     = $signed({{(SW-COMP_W){1'b0}}, g});
        bs     = $signed({{(SW-COMP_W){1'b0}}, b});
        y_acc  = (4 * rs + 8 * gs + 2 * bs + Y_BIAS) >>> 4;
        cb_acc = (C_BIAS - 2 * rs - 5 * gs + 7 * bs) >>> 4;
        cr_acc = (C_BIAS + 7 * rs - 6 * gs - bs) >>> 4;
        y      = sat(y_acc);
        cb     = sat(cb_acc);
        cr     = sat(cr_acc);
    end
endmodule

// File: rtl/pix_point_stage.sv
`timescale 1ns/1ps
// Streaming RGB point-operation stage with a single output register.
// Assumes R in the top byte; mode, offset and threshold are sampled at
// the input handshake. One cycle of latency; stalls follow the output.
module pix_point_stage
    import pix_op_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int OFS_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode,
    input  logic signed [OFS_W-1:0] bright_ofs,
    input  logic [COMP_W-1:0]       thresh,
    input  logic [3*COMP_W-1:0]     s_tdata,
    input  logic                    s_tuser,
    input  logic                    s_tlast,
    input  logic                    s_tvalid,
    output logic                    s_tready,
    output logic [3*COMP_W-1:0]     m_tdata,
    output logic                    m_tuser,
    output logic                    m_tlast,
    output logic                    m_tvalid,
    input  logic                    m_tready
);
    localparam int PIX_W = 3 * COMP_W;

    logic [COMP_W-1:0] comp [3];
    logic [COMP_W-1:0] inv_c [3];
    logic [COMP_W-1:0] brt_c [3];
    logic [COMP_W-1:0] gray, y_v, cb_v, cr_v;
    logic [PIX_W-1:0]  result;
    logic              take;

    // One lane unit per colour; lane 0 is red in the top byte.
    for (genvar i = 0; i < 3; i++) begin : g_lane
        assign comp[i] = s_tdata[(2-i)*COMP_W +: COMP_W];
        pix_lane_op #(.COMP_W(COMP_W), .OFS_W(OFS_W)) u_lane (
            .comp   (comp[i]),
            .ofs    (bright_ofs),
            .inv    (inv_c[i]),
            .bright (brt_c[i])
        );
    end

    pix_color_conv #(.COMP_W(COMP_W)) u_conv (
        .r    (comp[0]),
        .g    (comp[1]),
        .b    (comp[2]),
        .gray (gray),
        .y    (y_v),
        .cb   (cb_v),
        .cr   (cr_v)
    );

    // Select the operation result for the current mode.
    always_comb begin
        case (mode)
            OP_GRAY:   result = {3{gray}};
            OP_YCC:    result = {y_v, cb_v, cr_v};
            OP_INV:    result = {inv_c[0], inv_c[1], inv_c[2]};
            OP_BRIGHT: result = {brt_c[0], brt_c[1], brt_c[2]};
            OP_BIN:    result = (gray > thresh) ? '1 : '0;
            default:   result = s_tdata;
        endcase
    end

    // Accept when the register is empty or being drained this cycle.
    assign s_tready = !m_tvalid || m_tready;
    assign take     = s_tvalid && s_tready;

    // Output register: load on accept, clear when drained with no refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tuser  <= 1'b0;
            m_tlast  <= 1'b0;
        end else if (take) begin
            m_tvalid <= 1'b1;
            m_tdata  <= result;
            m_tuser  <= s_tuser;
            m_tlast  <= s_tlast;
        end else if (m_tready) begin
            m_tvalid <= 1'b0;
        end
    end

    // R8: a stalled output holds valid, data and flags.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=>
            (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));

    // R7: an accepted pixel is present on the output one cycle later.
    p_accept_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready) |=> m_tvalid);

    // R7: flags travel with the accepted pixel.
    p_flag_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready) |=> (m_tuser == $past(s_tuser) && m_tlast == $past(s_tlast)));

    // R5: binary mode yields only full black or full white.
    p_bin_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && mode == OP_BIN) |=> (m_tdata == '0 || m_tdata == '1));

    // R1: gray mode result is identical on all three lanes.
    p_gray_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && mode == OP_GRAY) |=>
            (m_tdata[PIX_W-1 -: COMP_W] == m_tdata[COMP_W +: COMP_W]
             && m_tdata[COMP_W +: COMP_W] == m_tdata[COMP_W-1:0]));

    // R10: reset empties the output register.
    p_reset_empty_r10: assert property (@(posedge clk) !rst_n |=> !m_tvalid);
endmodule

// File: tb/pix_point_stage_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected pixels at each handshake and
// the monitor compares them as the stage delivers results.
module pix_point_stage_test;
    typedef struct {
        logic [23:0] data;
        logic        user;
        logic        last;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode = '0;
    logic signed [8:0] bright_ofs = '0;
    logic [7:0]        thresh = '0;
    logic [23:0]       s_tdata = '0;
    logic              s_tuser = 1'b0, s_tlast = 1'b0, s_tvalid = 1'b0;
    logic              s_tready;
    logic [23:0]       m_tdata;
    logic              m_tuser, m_tlast, m_tvalid;
    logic              m_tready = 1'b1;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   stall_on = 1'b0;
    bit   done = 1'b0;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    pix_point_stage uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bright_ofs(bright_ofs),
        .thresh(thresh), .s_tdata(s_tdata), .s_tuser(s_tuser),
        .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    // Expected result computed from the requirement formulas.
    function automatic logic [23:0] model(input logic [23:0] px, input int md,
                                          input int ofs, input int thr);
        int r = px[23:16], g = px[15:8], b = px[7:0];
        int gr = ((r + g + b) * 171) / 512;
        logic [7:0] o0, o1, o2;
        case (md)
            0: begin o0 = 8'(gr); o1 = 8'(gr); o2 = 8'(gr); end
            1: begin
                o0 = 8'(clamp8((4*r + 8*g + 2*b + 256) / 16));
                o1 = 8'(clamp8((-2*r - 5*g + 7*b + 2048) / 16));
                o2 = 8'(clamp8((7*r - 6*g - b + 2048) / 16));
            end
            2: begin o0 = 8'(255 - r); o1 = 8'(255 - g); o2 = 8'(255 - b); end
            3: begin
                o0 = 8'(clamp8(r + ofs)); o1 = 8'(clamp8(g + ofs));
                o2 = 8'(clamp8(b + ofs));
            end
            4: begin
                o0 = (gr > thr) ? 8'hFF : 8'h00; o1 = o0; o2 = o0;
            end
            default: begin o0 = 8'(r); o1 = 8'(g); o2 = 8'(b); end
        endcase
        return {o0, o1, o2};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one pixel and queue its expectation at the handshake.
    task automatic send(input logic [23:0] px, input int md, input int ofs,
                        input int thr, input bit u, input bit l, input string tag);
        exp_t e;
        @(negedge clk);
        s_tdata = px; mode = 3'(md); bright_ofs = 9'(ofs); thresh = 8'(thr);
        s_tuser = u; s_tlast = l; s_tvalid = 1'b1;
        #1;
        while (!s_tready) begin
            @(negedge clk);
            #1;
        end
        e.data = model(px, md, ofs, thr); e.user = u; e.last = l; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: set downstream ready, then check handshake and stall rules.
    initial begin
        bit          prev_stall = 1'b0;
        logic [23:0] prev_data = '0;
        exp_t        e;
        forever begin
            @(negedge clk);
            m_tready = stall_on ? ($urandom_range(3) != 0) : 1'b1;
            #2;
            if (rst_n) begin
                if (prev_stall)
                    check(m_tvalid && m_tdata == prev_data, "R8 hold",
                          {7'd0, m_tvalid, m_tdata}, {8'd1, prev_data});
                if (m_tvalid && !m_tready)
                    check(!s_tready, "R9 ready low", 32'(s_tready), 32'd0);
                if (!m_tvalid)
                    check(s_tready, "R9 ready high", 32'(s_tready), 32'd1);
                if (m_tvalid && m_tready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R7 unexpected output", 32'(m_tdata), 32'd0);
                    end else begin
                        e = sb.pop_front();
                        check(m_tdata == e.data && m_tuser == e.user && m_tlast == e.last,
                              e.tag, {6'd0, m_tuser, m_tlast, m_tdata},
                              {6'd0, e.user, e.last, e.data});
                    end
                end
                prev_stall = m_tvalid && !m_tready;
                prev_data  = m_tdata;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(!m_tvalid, "R10 in reset", 32'(m_tvalid), 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!m_tvalid, "R10 after reset", 32'(m_tvalid), 32'd0);

        // R1 gray
        send(24'h000000, 0, 0, 0, 1, 0, "R1 gray black");
        send(24'hFFFFFF, 0, 0, 0, 0, 0, "R1 gray white");
        send(24'h10C8FF, 0, 0, 0, 0, 1, "R1 gray mix");
        // R2 YCbCr
        send(24'h000000, 1, 0, 0, 0, 0, "R2 ycc black");
        send(24'hFFFFFF, 1, 0, 0, 0, 0, "R2 ycc white");
        send(24'hFF0000, 1, 0, 0, 0, 0, "R2 ycc red");
        send(24'h0000FF, 1, 0, 0, 0, 1, "R2 ycc blue");
        // R3 invert
        send(24'h00FF5A, 2, 0, 0, 0, 0, "R3 invert");
        // R4 brightness: saturate high, low and unclamped mid
        send(24'hC80A64, 3, 100, 0, 0, 0, "R4 bright up clamp");
        send(24'h32F064, 3, -100, 0, 0, 0, "R4 bright down clamp");
        send(24'h808080, 3, -256, 0, 0, 0, "R4 bright min offset");
        send(24'h102030, 3, 255, 0, 0, 0, "R4 bright max offset");
        // R5 threshold equality and just below
        send(24'h646464, 4, 0, 100, 0, 0, "R5 bin equal");
        send(24'h646464, 4, 0, 99, 0, 0, "R5 bin above");
        send(24'hFFFFFF, 4, 0, 255, 0, 1, "R5 bin top");
        // R6 reserved codes
        send(24'h123456, 5, 50, 10, 0, 0, "R6 pass mode5");
        send(24'hABCDEF, 7, 50, 10, 1, 1, "R6 pass mode7");

        // R7 R8 R9 under random downstream stalls
        stall_on = 1'b1;
        for (int k = 0; k < 60; k++) begin
            logic [23:0] px;
            px = 24'($urandom);
            send(px, k % 8, int'($urandom_range(511)) - 256, int'($urandom_range(255)),
                 (k % 20) == 0, (k % 6) == 5, "R7 stream");
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        stall_on = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule